// File: doc/BRIEF.md
# Shared-Address Mode Register Pointer

This block gives bus access to three mode registers per channel, MR0, MR1 and MR2, through one byte-wide address. Each channel has a selection pointer that picks which of its three registers a mode-address read or write reaches. Every access moves the pointer one step forward. Once the pointer reaches the last register it stays there. Two command codes written to the channel's command address move the pointer back to the first or second register.

The block is built for two channels. Each channel has its own registers and its own pointer. Read and write strobes are level signals that may stay high for several clocks. The block acts once on each rising edge of a strobe. Read data is captured into an output register when the read is accepted. It holds that value until the next accepted read.

Top module: `mode_reg_port`

## Requirements
- R1: After reset, every mode register holds 0x00, `rdata_o` is 0x00, and each channel's pointer selects MR1.
- R2: `addr_i[0]` selects the mode address (0) or the command address (1). `addr_i[1]` selects channel 0 or channel 1.
- R3: A read of the mode address returns the currently selected register on `rdata_o` after the clock edge that accepts the read. The pointer then advances. `rdata_o` changes only when a read is accepted.
- R4: A write to the mode address stores `wdata_i` in the currently selected register, then advances the pointer.
- R5: Each access moves the pointer from MR0 to MR1 and from MR1 to MR2. At MR2 it stays at MR2 for every later access.
- R6: Writing 0xB0 to a channel's command address sets that channel's pointer to MR0. Writing 0x10 sets it to MR1. Any other code leaves the pointer unchanged.
- R7: One strobe moves the pointer exactly once, however many clocks it stays high.
- R8: An access or command on one channel leaves the other channel's pointer and registers unchanged.
- R9: A read of a command address returns 0x00 and does not move the pointer.
- R10: A rising read strobe is ignored while `wr_i` is high. The write is carried out, and `rdata_o` keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Bit 1 selects the channel; bit 0 selects mode (0) or command (1) |
| rd_i | input | 1 | Read strobe, level, acted upon at its rising edge |
| wr_i | input | 1 | Write strobe, level, acted upon at its rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
A wrong pointer value cannot be seen at the ports directly. It shows up on the next mode-address read of that channel, either as data from the wrong register or as data arriving one register early or late. A write to the wrong slot shows up only when that slot is next read back. For this reason the bench follows every write pattern with read sequences that return to MR0 and walk through all three registers. A strobe that is counted twice, or leaks into the other channel, appears at most two accesses later as a shifted read value.

// File: rtl/mr_ptr_pkg.sv
package mr_ptr_pkg;
  localparam int NUM_MR = 3;
  typedef enum logic [1:0] {
    SEL_MR0 = 2'd0,
    SEL_MR1 = 2'd1,
    SEL_MR2 = 2'd2
  } mr_sel_e;
  localparam logic [7:0] CMD_SEL_MR0 = 8'hB0;
  localparam logic [7:0] CMD_SEL_MR1 = 8'h10;
endpackage

// File: rtl/mr_edge_det.sv
module mr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~strobe_q;

  // a held strobe gives a single pulse
  p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/mr_sel_ptr.sv
module mr_sel_ptr
  import mr_ptr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_i,
  input  logic       cmd_vld_i,
  input  logic [7:0] cmd_i,
  output mr_sel_e    sel_o
);
  mr_sel_e sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (cmd_vld_i) begin
      if (cmd_i == CMD_SEL_MR0)      sel_d = SEL_MR0;
      else if (cmd_i == CMD_SEL_MR1) sel_d = SEL_MR1;
    end else if (acc_i) begin
      unique case (sel_q)
        SEL_MR0: sel_d = SEL_MR1;
        SEL_MR1: sel_d = SEL_MR2;
        default: sel_d = SEL_MR2;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= SEL_MR1;
    else         sel_q <= sel_d;
  end

  assign sel_o = sel_q;

  p_adv_from_mr0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !cmd_vld_i && sel_q == SEL_MR0) |=> sel_q == SEL_MR1);
  p_adv_from_mr1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !cmd_vld_i && sel_q == SEL_MR1) |=> sel_q == SEL_MR2);
  p_stick_mr2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !cmd_vld_i && sel_q == SEL_MR2) |=> sel_q == SEL_MR2);
  p_cmd_mr0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && cmd_i == CMD_SEL_MR0) |=> sel_q == SEL_MR0);
  p_cmd_mr1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && cmd_i == CMD_SEL_MR1) |=> sel_q == SEL_MR1);
  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && !cmd_vld_i) |=> $stable(sel_q));
  p_sel_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q != 2'd3);
endmodule

// File: rtl/mr_bank.sv
module mr_bank
  import mr_ptr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  mr_sel_e       sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] regs_q [NUM_MR];

  for (genvar i = 0; i < NUM_MR; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            regs_q[i] <= '0;
      else if (we_i && sel_i == mr_sel_e'(i)) regs_q[i] <= wdata_i;
    end

    p_no_stray_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && sel_i == mr_sel_e'(i)) |=> $stable(regs_q[i]));
  end

  always_comb begin
    unique case (sel_i)
      SEL_MR0: rdata_o = regs_q[0];
      SEL_MR1: rdata_o = regs_q[1];
      default: rdata_o = regs_q[2];
    endcase
  end
endmodule

// File: rtl/mode_reg_port.sv
module mode_reg_port
  import mr_ptr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW     = 8,
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW    = CHW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic rd_rise, wr_rise, rd_fire, wr_fire, is_cmd;
  logic [CHW-1:0] ch_idx;
  logic [DW-1:0]  ch_rdata [NUM_CH];
  logic [DW-1:0]  rdata_q, rd_mux;

  mr_edge_det u_rd_edge (.clk_i, .rst_ni, .strobe_i(rd_i), .rise_o(rd_rise));
  mr_edge_det u_wr_edge (.clk_i, .rst_ni, .strobe_i(wr_i), .rise_o(wr_rise));

  assign wr_fire = wr_rise;
  assign rd_fire = rd_rise & ~wr_i;  // write wins a collision
  assign is_cmd  = addr_i[0];
  assign ch_idx  = addr_i[AW-1:1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic    hit, acc, cmd_vld, we;
    mr_sel_e sel;

    assign hit     = (ch_idx == CHW'(c));
    assign acc     = hit & ~is_cmd & (wr_fire | rd_fire);
    assign we      = hit & ~is_cmd & wr_fire;
    assign cmd_vld = hit &  is_cmd & wr_fire;

    mr_sel_ptr u_ptr (
      .clk_i, .rst_ni,
      .acc_i    (acc),
      .cmd_vld_i(cmd_vld),
      .cmd_i    (wdata_i[7:0]),
      .sel_o    (sel)
    );

    mr_bank #(.DW(DW)) u_bank (
      .clk_i, .rst_ni,
      .we_i   (we),
      .sel_i  (sel),
      .wdata_i(wdata_i),
      .rdata_o(ch_rdata[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (ch_idx == CHW'(c)) rd_mux = ch_rdata[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_fire) rdata_q <= is_cmd ? '0 : rd_mux;
  end

  assign rdata_o = rdata_q;

  p_rdata_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_fire |=> $stable(rdata_o));
  p_cmd_read_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && is_cmd) |=> rdata_o == '0);
  p_collide_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rise && wr_i) |=> $stable(rdata_o));
endmodule

// File: tb/sim_mode_reg_port.sv
module sim_mode_reg_port;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int n_chk = 0, n_fail = 0;
  int mptr [2];
  logic [7:0] mreg [2][3];
  logic [7:0] last_rd;

  always #(CLK_P/2) clk = ~clk;

  mode_reg_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic void m_adv(input int ch);
    mptr[ch] = (mptr[ch] < 2) ? mptr[ch] + 1 : 2;
  endfunction

  task automatic strobe(input bit is_wr, input bit is_cmd, input int ch,
                        input logic [7:0] d, input int hold);
    @(negedge clk);
    addr = {ch[0], is_cmd};
    wdata = d;
    if (is_wr) wr = 1'b1; else rd = 1'b1;
    repeat (hold) @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic mwrite(input int ch, input logic [7:0] d, input int hold);
    strobe(1'b1, 1'b0, ch, d, hold);
    mreg[ch][mptr[ch]] = d;
    m_adv(ch);
  endtask

  task automatic mcmd(input int ch, input logic [7:0] code, input int hold);
    strobe(1'b1, 1'b1, ch, code, hold);
    if (code == 8'hB0) mptr[ch] = 0;
    else if (code == 8'h10) mptr[ch] = 1;
  endtask

  task automatic mread(input int ch, input int hold, input string req);
    strobe(1'b0, 1'b0, ch, 8'h00, hold);
    last_rd = mreg[ch][mptr[ch]];
    check(req, rdata, last_rd);
    m_adv(ch);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      mptr[c] = 1;
      for (int r = 0; r < 3; r++) mreg[c][r] = 8'h00;
    end
    last_rd = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 rdata reset", rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: both channels start at MR1 with zero contents
    mwrite(0, 8'h5A, 1);            // lands in MR1 per R1/R4
    mcmd(0, 8'hB0, 1);
    mread(0, 1, "R1 MR0 zero");
    mread(0, 1, "R1 MR1 written first");
    mread(1, 1, "R1 ch1 MR1 zero");
    mread(1, 1, "R1 ch1 MR2 zero");

    for (int c = 0; c < 2; c++) begin
      for (int h = 1; h <= 3; h++) begin
        // R4 R5: fill walk from MR0, fourth write sticks at MR2
        mcmd(c, 8'hB0, h);
        for (int k = 0; k < 4; k++)
          mwrite(c, 8'(37*k + 11*h + 90*c + 5), h);
        // R6 R3: back to MR1, reads walk and stick
        mcmd(c, 8'h10, h);
        mread(c, h, "R6 cmd 0x10 -> MR1");
        mread(c, h, "R5 MR1 -> MR2");
        mread(c, h, "R5 stick MR2");
        // R7: long strobes advanced once each
        mcmd(c, 8'hB0, h);
        mread(c, h, "R7 MR0 after B0");
        // R9: command read gives zero and no advance
        strobe(1'b0, 1'b1, c, 8'h00, h);
        last_rd = 8'h00;
        check("R9 cmd read zero", rdata, 8'h00);
        mread(c, h, "R9 no advance");
        // R6: unknown codes ignored
        mcmd(c, 8'hB1, h);
        mcmd(c, 8'h30, h);
        mread(c, h, "R6 unknown code ignored");
        // R8: other channel untouched
        mcmd(1 - c, 8'hB0, 1);
        for (int k = 0; k < 3; k++)
          mread(1 - c, 1, "R8 other channel intact");
        // R10: read and write rise together
        mcmd(c, 8'hB0, 1);
        @(negedge clk);
        addr = {c[0], 1'b0};
        wdata = 8'(8'hC3 ^ 8'(h*7 + c));
        rd = 1'b1; wr = 1'b1;
        repeat (h) @(negedge clk);
        rd = 1'b0; wr = 1'b0;
        @(negedge clk);
        check("R10 rdata held", rdata, last_rd);
        mreg[c][0] = 8'(8'hC3 ^ 8'(h*7 + c));
        m_adv(c);
        mread(c, 1, "R10 advanced once to MR1");
        mcmd(c, 8'hB0, 1);
        mread(c, 1, "R10 write landed in MR0");
        // R2: addressing, ch bit picks bank
        mcmd(c, 8'hB0, 1);
        mcmd(1 - c, 8'h10, 1);
        mread(c, 1, "R2 channel select");
        mread(1 - c, 1, "R2 channel select");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule